// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block takes one summary beat per completed received frame (byte count and error flags) and records it in a ring of receive descriptors. The descriptors live in a small internal store that a host port can read and write. Software hands a descriptor to the engine by setting its EMPTY bit. The engine fills only descriptors that are EMPTY. When it fills one, it clears EMPTY, writes the length (with the four frame-check bytes added) and the error flags, and moves to the next descriptor. After filling a descriptor whose WRAP bit is set, it goes back to the ring base.

If a frame arrives while the current descriptor still belongs to software, the ring is full. The frame is consumed and thrown away whole, a sticky BUSY event is raised, and reception halts until software writes the halt-clear bit. A graceful stop request lets any frame already being offered finish, then stops reception at the frame boundary and raises a stop-done event. Events are sticky and cleared by writing 1. The interrupt output is the OR of the events enabled by a mask.

The frame input is a valid/ready stream with one beat per frame. The engine holds `frm_ready` low while halted or stopped, and the source must then keep the beat (valid, length and errors) stable until ready returns. When a beat meets a full ring, the engine accepts it with ready high and discards it. The host port is a plain single-cycle write strobe with a combinational read.

Top module: `rx_desc_ring`

## Requirements
- R1: After reset the ring base and current index are 0, all event bits are 0, the engine is not halted or stopped, `frm_ready` is 1, `irq` is 0, and every descriptor word reads 0, so no descriptor is EMPTY.
- R2: A frame accepted while the current descriptor has EMPTY (bit 31) set rewrites that descriptor's status word. Bit 31 becomes 0, WRAP (bit 30) keeps its value, bits 29:22 become 0, the error flags go to bits 21:16, and bits 15:0 hold the frame length plus 4. The buffer-pointer word is left unchanged, and event bit 2 (frame) is set.
- R3: After a fill, the current index advances by one. If the filled descriptor had WRAP set, the next index is the ring base instead. Past the last descriptor without WRAP, the index returns to 0.
- R4: A frame accepted while the current descriptor has EMPTY clear is discarded, and no descriptor word changes. Event bit 0 (busy) is set, the halt flag (status register bit 0) is set, and `frm_ready` stays 0 while halted.
- R5: Writing the event register clears each bit written as 1 and leaves bits written as 0. An event raised in the same cycle as a clear of that bit stays set.
- R6: Writing 1 to status register bit 0 clears the halt. Reception then resumes at the same current index.
- R7: Writing 1 to control bit 0 requests a graceful stop. A frame accepted in the cycle the stop takes hold is still filled. From then on `frm_ready` is 0, event bit 1 (stop done) is set, and control reads back 3. Writing 0 releases the stop one cycle later.
- R8: `irq` is 1 exactly when some event bit is set whose mask bit is also set.
- R9: Writing the base register sets both the ring base and the current index to the written value.
- R10: The host reads and writes descriptor i at address 0x40+2i (status word) and 0x41+2i (buffer pointer). Registers are at 0x00 base, 0x01 event, 0x02 mask, 0x03 status and 0x04 control. When the host and the engine write the same status word in one cycle, the engine's write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_valid | input | 1 | Frame summary beat valid |
| frm_ready | output | 1 | Engine accepts the beat this cycle |
| frm_len | input | LEN_W | Frame byte count without the check sequence |
| frm_err | input | ERR_W | Receive error flags of the frame |
| hst_we | input | 1 | Host write strobe |
| hst_addr | input | AW | Host word address |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Host read data for `hst_addr` |
| irq | output | 1 | Masked event interrupt |

## Verification
Two kinds of work can land on the same clock edge. The first is the engine's own event or descriptor update meeting a host write: a full-ring frame arrives together with a write-one-to-clear of the busy bit, and a frame fill hits the same status word the host is rewriting. The second is a frame handshake meeting the graceful stop taking hold. The bench drives both parties in the same cycle from one stimulus step. It then reads back the event register, the descriptor words and `frm_ready`, and judges that the set beat the clear, the engine's write beat the host's, and the frame offered at the stop boundary was filled while the next one was refused.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  localparam int WORD_W    = 32;
  localparam int FCS_BYTES = 4;
  // status word bit positions
  localparam int D_EMPTY   = 31;
  localparam int D_WRAP    = 30;
  localparam int D_ERR_LSB = 16;
  // event bits
  localparam int EV_BUSY   = 0;
  localparam int EV_STOP   = 1;
  localparam int EV_FRAME  = 2;
  localparam int EV_W      = 3;
  // host register word addresses
  localparam int A_BASE    = 'h00;
  localparam int A_EVENT   = 'h01;
  localparam int A_MASK    = 'h02;
  localparam int A_STAT    = 'h03;
  localparam int A_CTRL    = 'h04;
  localparam int A_DESC    = 'h40;
endpackage

// File: rtl/rxr_desc_mem.sv
module rxr_desc_mem #(
  parameter int NDESC = 8
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             h_we,
  input  logic [$clog2(2*NDESC)-1:0]       h_idx,
  input  logic [rxr_pkg::WORD_W-1:0]       h_wdata,
  output logic [rxr_pkg::WORD_W-1:0]       h_rdata,
  input  logic                             e_we,
  input  logic [$clog2(NDESC)-1:0]         e_idx,
  input  logic [rxr_pkg::WORD_W-1:0]       e_wdata,
  output logic [rxr_pkg::WORD_W-1:0]       e_word0
);
  localparam int NWORD = 2 * NDESC;
  localparam int WIW   = $clog2(NWORD);

  logic [rxr_pkg::WORD_W-1:0] mem [NWORD];
  logic [WIW-1:0]             e_widx;

  assign e_widx  = {e_idx, 1'b0};
  assign h_rdata = mem[h_idx];
  assign e_word0 = mem[e_widx];

  always_ff @(posedge clk) begin
    for (int w = 0; w < NWORD; w++) begin
      if (!rst_n) begin
        mem[w] <= '0;
      end else if (e_we && (e_widx == WIW'(w))) begin
        mem[w] <= e_wdata;
      end else if (h_we && (h_idx == WIW'(w))) begin
        mem[w] <= h_wdata;
      end
    end
  end
endmodule

// File: rtl/rxr_regs.sv
module rxr_regs #(
  parameter int IW = 3,
  parameter int AW = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        h_we,
  input  logic [AW-1:0]               h_addr,
  input  logic [rxr_pkg::WORD_W-1:0]  h_wdata,
  input  logic                        set_busy,
  input  logic                        set_frame,
  output logic [IW-1:0]               base,
  output logic                        base_wr,
  output logic [IW-1:0]               base_new,
  output logic [rxr_pkg::EV_W-1:0]    ev_q,
  output logic                        halted,
  output logic                        stopped,
  output logic                        irq,
  output logic [rxr_pkg::WORD_W-1:0]  reg_rdata
);
  import rxr_pkg::*;

  logic [EV_W-1:0] mask_q, ev_set, ev_clr;
  logic            stop_req, stop_done, halt_clr;
  logic            wr_ev, wr_mask, wr_stat, wr_ctrl;
  logic            unused_wdata;

  assign unused_wdata = ^h_wdata;

  assign base_wr  = h_we && (h_addr == AW'(A_BASE));
  assign wr_ev    = h_we && (h_addr == AW'(A_EVENT));
  assign wr_mask  = h_we && (h_addr == AW'(A_MASK));
  assign wr_stat  = h_we && (h_addr == AW'(A_STAT));
  assign wr_ctrl  = h_we && (h_addr == AW'(A_CTRL));
  assign base_new = h_wdata[IW-1:0];
  assign halt_clr = wr_stat && h_wdata[0];

  assign stop_done = stop_req && !stopped;

  always_comb begin
    ev_set           = '0;
    ev_set[EV_BUSY]  = set_busy;
    ev_set[EV_STOP]  = stop_done;
    ev_set[EV_FRAME] = set_frame;
    ev_clr           = wr_ev ? h_wdata[EV_W-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base     <= '0;
      mask_q   <= '0;
      ev_q     <= '0;
      halted   <= 1'b0;
      stop_req <= 1'b0;
      stopped  <= 1'b0;
    end else begin
      if (base_wr) base <= base_new;
      if (wr_mask) mask_q <= h_wdata[EV_W-1:0];
      ev_q <= (ev_q & ~ev_clr) | ev_set;
      if (set_busy)      halted <= 1'b1;
      else if (halt_clr) halted <= 1'b0;
      if (wr_ctrl) stop_req <= h_wdata[0];
      stopped <= stop_req;
    end
  end

  assign irq = |(ev_q & mask_q);

  always_comb begin
    reg_rdata = '0;
    case (int'(h_addr))
      A_BASE:  reg_rdata[IW-1:0]   = base;
      A_EVENT: reg_rdata[EV_W-1:0] = ev_q;
      A_MASK:  reg_rdata[EV_W-1:0] = mask_q;
      A_STAT:  reg_rdata[0]        = halted;
      A_CTRL:  reg_rdata[1:0]      = {stopped, stop_req};
      default: reg_rdata           = '0;
    endcase
  end
endmodule

// File: rtl/rxr_engine.sv
module rxr_engine #(
  parameter int NDESC = 8,
  parameter int LEN_W = 16,
  parameter int ERR_W = 6
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          frm_valid,
  output logic                          frm_ready,
  input  logic [LEN_W-1:0]              frm_len,
  input  logic [ERR_W-1:0]              frm_err,
  input  logic                          halted,
  input  logic                          stopped,
  input  logic [$clog2(NDESC)-1:0]      base,
  input  logic                          base_wr,
  input  logic [$clog2(NDESC)-1:0]      base_new,
  input  logic [rxr_pkg::WORD_W-1:0]    cur_word0,
  output logic [$clog2(NDESC)-1:0]      idx,
  output logic                          e_we,
  output logic [rxr_pkg::WORD_W-1:0]    e_wdata,
  output logic                          set_busy,
  output logic                          set_frame
);
  import rxr_pkg::*;
  localparam int IW = $clog2(NDESC);

  logic          take, cur_empty, cur_wrap;
  logic [IW-1:0] idx_inc;
  logic          unused_word;

  assign unused_word = ^cur_word0;
  assign cur_empty   = cur_word0[D_EMPTY];
  assign cur_wrap    = cur_word0[D_WRAP];

  assign frm_ready = !halted && !stopped;
  assign take      = frm_valid && frm_ready;
  assign e_we      = take && cur_empty;
  assign set_frame = e_we;
  assign set_busy  = take && !cur_empty;

  always_comb begin
    e_wdata                      = '0;
    e_wdata[D_WRAP]              = cur_wrap;
    e_wdata[D_ERR_LSB +: ERR_W]  = frm_err;
    e_wdata[LEN_W-1:0]           = frm_len + LEN_W'(FCS_BYTES);
  end

  assign idx_inc = (idx == IW'(NDESC - 1)) ? '0 : idx + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n)      idx <= '0;
    else if (base_wr) idx <= base_new;
    else if (e_we)   idx <= cur_wrap ? base : idx_inc;
  end
endmodule

// File: rtl/rx_desc_ring.sv
module rx_desc_ring #(
  parameter int NDESC = 8,
  parameter int LEN_W = 16,
  parameter int ERR_W = 6,
  parameter int AW    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frm_valid,
  output logic              frm_ready,
  input  logic [LEN_W-1:0]  frm_len,
  input  logic [ERR_W-1:0]  frm_err,
  input  logic              hst_we,
  input  logic [AW-1:0]     hst_addr,
  input  logic [31:0]       hst_wdata,
  output logic [31:0]       hst_rdata,
  output logic              irq
);
  import rxr_pkg::*;
  localparam int IW    = $clog2(NDESC);
  localparam int WIW   = $clog2(2 * NDESC);
  localparam int D_END = A_DESC + 2 * NDESC;

  logic [IW-1:0]     base, base_new, idx;
  logic              base_wr, halted, stopped;
  logic [EV_W-1:0]   ev_q;
  logic              e_we, set_busy, set_frame;
  logic [WORD_W-1:0] e_wdata, cur_word0, mem_rdata, reg_rdata;
  logic              in_desc, mem_we;
  logic [WIW-1:0]    mem_idx;
  logic [AW-1:0]     addr_off;

  assign in_desc  = (int'(hst_addr) >= A_DESC) && (int'(hst_addr) < D_END);
  assign addr_off = hst_addr - AW'(A_DESC);
  assign mem_idx  = addr_off[WIW-1:0];
  assign mem_we   = hst_we && in_desc;

  rxr_desc_mem #(.NDESC(NDESC)) u_mem (
    .clk(clk), .rst_n(rst_n),
    .h_we(mem_we), .h_idx(mem_idx), .h_wdata(hst_wdata), .h_rdata(mem_rdata),
    .e_we(e_we), .e_idx(idx), .e_wdata(e_wdata), .e_word0(cur_word0)
  );

  rxr_regs #(.IW(IW), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .h_we(hst_we), .h_addr(hst_addr), .h_wdata(hst_wdata),
    .set_busy(set_busy), .set_frame(set_frame),
    .base(base), .base_wr(base_wr), .base_new(base_new),
    .ev_q(ev_q), .halted(halted), .stopped(stopped), .irq(irq),
    .reg_rdata(reg_rdata)
  );

  rxr_engine #(.NDESC(NDESC), .LEN_W(LEN_W), .ERR_W(ERR_W)) u_eng (
    .clk(clk), .rst_n(rst_n),
    .frm_valid(frm_valid), .frm_ready(frm_ready),
    .frm_len(frm_len), .frm_err(frm_err),
    .halted(halted), .stopped(stopped),
    .base(base), .base_wr(base_wr), .base_new(base_new),
    .cur_word0(cur_word0), .idx(idx),
    .e_we(e_we), .e_wdata(e_wdata),
    .set_busy(set_busy), .set_frame(set_frame)
  );

  assign hst_rdata = in_desc ? mem_rdata : reg_rdata;
endmodule

// File: rtl/rx_desc_ring_chk.sv
module rx_desc_ring_chk #(
  parameter int IW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          frm_valid,
  input logic          frm_ready,
  input logic          halted,
  input logic          stopped,
  input logic          cur_empty,
  input logic          cur_wrap,
  input logic [IW-1:0] idx,
  input logic [IW-1:0] base,
  input logic          base_wr,
  input logic [2:0]    ev_q,
  input logic          irq,
  input logic          e_we
);
  a_r4_no_ready_halted: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !frm_ready);

  a_r7_no_ready_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    stopped |-> !frm_ready);

  a_r4_full_halts: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && frm_ready && !cur_empty) |=> (halted && ev_q[0]));

  a_r4_full_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && frm_ready && !cur_empty) |-> !e_we);

  a_r2_fill_event: assert property (@(posedge clk) disable iff (!rst_n)
    e_we |=> ev_q[2]);

  a_r3_wrap_to_base: assert property (@(posedge clk) disable iff (!rst_n)
    (e_we && cur_wrap && !base_wr) |=> (idx == $past(base)));

  a_r7_stop_event: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stopped) |-> ev_q[1]);

  a_r8_irq_has_event: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ev_q != 3'b000));
endmodule

bind rx_desc_ring rx_desc_ring_chk #(.IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .frm_valid(frm_valid), .frm_ready(frm_ready),
  .halted(halted), .stopped(stopped),
  .cur_empty(cur_word0[rxr_pkg::D_EMPTY]), .cur_wrap(cur_word0[rxr_pkg::D_WRAP]),
  .idx(idx), .base(base), .base_wr(base_wr),
  .ev_q(ev_q), .irq(irq), .e_we(e_we)
);

// File: tb/rx_desc_ring_tb.sv
module rx_desc_ring_tb;
  localparam int NDESC = 8;
  localparam int LEN_W = 16;
  localparam int ERR_W = 6;
  localparam int AW    = 8;
  localparam logic [31:0] EMPTY = 32'h8000_0000;
  localparam logic [31:0] WRAP  = 32'h4000_0000;

  // table entry: {len[15:0], err[7:0], expected descriptor index[7:0]}
  localparam int NVEC = 6;
  localparam logic [31:0] VEC [NVEC] = '{
    {16'd60,    8'h00, 8'd0},
    {16'd1514,  8'h01, 8'd1},
    {16'd0,     8'h00, 8'd2},
    {16'd65531, 8'h3F, 8'd3},
    {16'd100,   8'h20, 8'd4},
    {16'd200,   8'h00, 8'd5}
  };

  logic             clk = 1'b0;
  logic             rst_n;
  logic             frm_valid;
  logic             frm_ready;
  logic [LEN_W-1:0] frm_len;
  logic [ERR_W-1:0] frm_err;
  logic             hst_we;
  logic [AW-1:0]    hst_addr;
  logic [31:0]      hst_wdata;
  logic [31:0]      hst_rdata;
  logic             irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  rx_desc_ring #(.NDESC(NDESC), .LEN_W(LEN_W), .ERR_W(ERR_W), .AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .frm_valid(frm_valid), .frm_ready(frm_ready),
    .frm_len(frm_len), .frm_err(frm_err),
    .hst_we(hst_we), .hst_addr(hst_addr), .hst_wdata(hst_wdata),
    .hst_rdata(hst_rdata), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // called at a falling edge; drives one cycle, returns at the next falling edge idle
  task automatic step(input logic we, input int addr, input logic [31:0] wd,
                      input logic fv, input int len, input int err);
    hst_we    = we;
    hst_addr  = AW'(addr);
    hst_wdata = wd;
    frm_valid = fv;
    frm_len   = LEN_W'(len);
    frm_err   = ERR_W'(err);
    @(negedge clk);
    hst_we    = 1'b0;
    frm_valid = 1'b0;
  endtask

  task automatic wr(input int addr, input logic [31:0] wd);
    step(1'b1, addr, wd, 1'b0, 0, 0);
  endtask

  task automatic frame(input int len, input int err);
    step(1'b0, 0, 32'h0, 1'b1, len, err);
  endtask

  task automatic rd(input int addr, output logic [31:0] d);
    hst_addr = AW'(addr);
    #1;
    d = hst_rdata;
  endtask

  function automatic logic [31:0] exp_w0(input logic wrap, input int err, input int len);
    return {1'b0, wrap, 8'h00, 6'(err), 16'(len + 4)};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; frm_valid = 1'b0; frm_len = '0; frm_err = '0;
    hst_we = 1'b0; hst_addr = '0; hst_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 ready", 32'(frm_ready), 32'd1);
    check("R1 irq", 32'(irq), 32'd0);
    rd('h01, d); check("R1 event", d, 32'd0);
    rd('h03, d); check("R1 halt", d, 32'd0);
    rd('h00, d); check("R1 base", d, 32'd0);
    rd('h4A, d); check("R1 desc word", d, 32'd0);

    // arm ring: all EMPTY, descriptor 5 carries WRAP; pointers 0x1000+i*0x100
    for (int i = 0; i < NDESC; i++) begin
      wr('h40 + 2*i, (i == 5) ? (EMPTY | WRAP) : EMPTY);
      wr('h41 + 2*i, 32'h1000 + 32'(i) * 32'h100);
    end
    wr('h02, 32'h1);  // mask: busy only

    // R2/R3 table of frames
    for (int v = 0; v < NVEC; v++) begin
      int len, err, ix;
      len = int'(VEC[v][31:16]);
      err = int'(VEC[v][15:8]);
      ix  = int'(VEC[v][7:0]);
      frame(len, err);
      rd('h40 + 2*ix, d);
      check($sformatf("R2 R3 fill vec%0d", v), d, exp_w0(ix == 5, err, len));
    end
    rd('h41 + 2*2, d); check("R2 pointer kept", d, 32'h1200);
    rd('h01, d); check("R2 frame event", d, 32'h4);
    check("R8 masked frame event", 32'(irq), 32'd0);

    // R4 wrap led to base 0, which is full now
    frame(77, 0);
    rd('h40, d); check("R4 desc0 unchanged", d, exp_w0(1'b0, 0, 60));
    rd('h03, d); check("R4 halt set", d, 32'd1);
    rd('h01, d); check("R4 busy event", d, 32'h5);
    check("R4 ready low", 32'(frm_ready), 32'd0);
    check("R8 irq busy", 32'(irq), 32'd1);
    frame(5, 0);
    rd('h4C, d); check("R4 halted no fill", d, EMPTY);

    // R5 write one clears only that bit
    wr('h01, 32'h1);
    rd('h01, d); check("R5 w1c", d, 32'h4);
    check("R8 irq cleared", 32'(irq), 32'd0);

    // R6 clear halt, resume at index 0
    wr('h03, 32'h1);
    rd('h03, d); check("R6 halt cleared", d, 32'd0);
    check("R6 ready back", 32'(frm_ready), 32'd1);
    wr('h40, EMPTY);
    frame(10, 2);
    rd('h40, d); check("R6 resume at same index", d, exp_w0(1'b0, 2, 10));
    rd('h4C, d); check("R3 wrap skipped desc6", d, EMPTY);

    // R9 base write, R3 end of ring back to 0
    wr('h00, 32'd6);
    rd('h00, d); check("R9 base", d, 32'd6);
    frame(20, 0);
    rd('h4C, d); check("R9 fill at new base", d, exp_w0(1'b0, 0, 20));
    frame(30, 0);
    rd('h4E, d); check("R3 last desc", d, exp_w0(1'b0, 0, 30));
    wr('h40, EMPTY);
    frame(40, 0);
    rd('h40, d); check("R3 end wraps to 0", d, exp_w0(1'b0, 0, 40));

    // R5 busy raised in the cycle the host clears it: set wins
    step(1'b1, 'h01, 32'h1, 1'b1, 50, 0);
    rd('h01, d); check("R5 set beats clear", d, 32'h5);
    rd('h42, d); check("R4 desc1 unchanged", d, exp_w0(1'b0, 1, 1514));
    wr('h01, 32'h7);
    wr('h03, 32'h1);
    rd('h01, d); check("R5 all cleared", d, 32'h0);

    // R7 graceful stop with a frame at the boundary
    wr('h42, EMPTY);
    wr('h44, EMPTY);
    wr('h04, 32'h1);
    frame(8, 0);
    rd('h42, d); check("R7 boundary frame filled", d, exp_w0(1'b0, 0, 8));
    check("R7 ready low", 32'(frm_ready), 32'd0);
    rd('h01, d); check("R7 stop event", d, 32'h6);
    rd('h04, d); check("R7 ctrl readback", d, 32'h3);
    frame(9, 0);
    rd('h44, d); check("R7 stopped no fill", d, EMPTY);
    wr('h04, 32'h0);
    step(1'b0, 0, 32'h0, 1'b0, 0, 0);
    check("R7 released", 32'(frm_ready), 32'd1);

    // R10 engine and host write the same status word
    step(1'b1, 'h44, 32'h8000_0ABC, 1'b1, 16, 3);
    rd('h44, d); check("R10 engine wins", d, exp_w0(1'b0, 3, 16));
    rd('h47, d); check("R10 pointer word", d, 32'h1300);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule